// File: doc/BRIEF.md
# Multi-Format Serial PCM Audio Receiver

This block turns a three-wire stereo audio stream into parallel samples. The three wires are a bit clock, a frame clock and a serial data line. It accepts four framings: I2S, left-justified, right-justified, and a DSP-style framing in which the frame signal is a start marker only. Each sample is carried most significant bit first in two's complement and may be 16, 20 or 24 bits long.

Every word is presented as a sign-extended 24-bit value on a left or right output. A one-cycle strobe marks each new word. The block runs entirely on the bit clock, and the consumer samples its outputs in that same domain.

Framing and word length are static configuration inputs. The bit clock may be gated or sent in bursts. The receiver therefore counts only the edges it actually sees and never relies on a fixed number of bits per frame.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is held, both data outputs are zero and both strobes are low. After reset, no strobe appears until the frame line has changed level at least once (or, in DSP framing, has risen).
- R2: Configuration encodings are as follows. cfg_mode: 0 = I2S, 1 = left-justified, 2 = right-justified, 3 = DSP. cfg_width: 0 = 24 bits, 1 = 20 bits, 2 = 16 bits, 3 = 24 bits. All-zero inputs therefore select I2S with 24-bit words.
- R3: In I2S framing, the MSB is the data bit captured on the second rising bit-clock edge after a frame-line change. Frame low means left. The strobe is high for the bit-clock cycle that follows the edge that captured the LSB.
- R4: In left-justified framing, the MSB is the bit captured on the first rising edge after a frame-line change, and frame high means left. The strobe timing is the same as in R3.
- R5: In right-justified framing, the word is the last N bits captured before a frame-line change, where N is the selected width. Any earlier bits in that half-frame are ignored. The channel is the frame level before the change, with high meaning left. The strobe appears in the cycle after the edge that sees the change. The first half-frame after reset is never emitted.
- R6: In DSP framing, only a rising frame line starts a frame. The bit captured on the first edge that sees it high is the left MSB. The right word follows directly after the last left bit. A falling frame line does not restart the count.
- R7: A word shorter than 24 bits is sign-extended into the upper output bits.
- R8: Each strobe lasts exactly one cycle, and the left and right strobes are never high together. Each data output holds its value between its own strobes.
- R9: Any number of bits per half-frame at or above the minimum for the framing is accepted, including pauses of the bit clock inside a word. Bits after the end of a word, as well as padding bits, produce no extra strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Serial bit clock; all state is updated on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Frame clock (level or marker, depending on framing) |
| sdata_i | input | 1 | Serial audio data, MSB first |
| cfg_mode | input | 2 | Framing select (R2 encoding) |
| cfg_width | input | 2 | Word length select (R2 encoding) |
| left_data | output | 24 | Last complete left word, sign-extended |
| left_valid | output | 1 | One-cycle strobe for a new left word |
| right_data | output | 24 | Last complete right word, sign-extended |
| right_valid | output | 1 | One-cycle strobe for a new right word |

## Verification
The sign-extension property assumes the width select stays static between reset and the strobe, so it is guarded by a stability check on that input. The bench changes the configuration only while reset is held.

The strobe and hold properties assume nothing about frame timing. Even so, the stimulus always provides at least the minimum number of bits per half-frame for the selected framing and fills the spare slots with ones, so that stray bits would show up in the data.

Clock pauses are inserted only while the bit clock is low, so every captured bit still sees one clean rising edge.

// File: rtl/pcm_rx_pkg.sv
`timescale 1ns/1ps
package pcm_rx_pkg;
   typedef enum logic [1:0] {
      FMT_I2S  = 2'd0,
      FMT_LEFT = 2'd1,
      FMT_RGHT = 2'd2,
      FMT_DSP  = 2'd3
   } fmt_e;

   typedef enum logic [1:0] {
      WID_FULL  = 2'd0,
      WID_MID   = 2'd1,
      WID_SHORT = 2'd2,
      WID_ALT   = 2'd3
   } wid_e;
endpackage

// File: rtl/pcm_rx_framer.sv
`timescale 1ns/1ps
// Tracks frame-line changes and counts bit-clock edges since the last start.
module pcm_rx_framer #(
   parameter int CNT_W = 7
) (
   input  logic             clk_bit,
   input  logic             rst_n,
   input  logic             frame_i,
   input  logic             marker_only,
   output logic             start_o,
   output logic [CNT_W-1:0] pos_o,
   output logic             lvl_prev_o,
   output logic             armed_o
);
   localparam logic [CNT_W-1:0] POS_SAT = '1;

   logic             primed_q;
   logic             lvl_q;
   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      start_o = primed_q && (frame_i != lvl_q) && (!marker_only || frame_i);
      if (start_o)
         pos_o = '0;
      else if (cnt_q == POS_SAT)
         pos_o = POS_SAT;
      else
         pos_o = cnt_q + 1'b1;
   end

   always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n) begin
         primed_q <= 1'b0;
         lvl_q    <= 1'b0;
         armed_q  <= 1'b0;
         cnt_q    <= POS_SAT;
      end else begin
         primed_q <= 1'b1;
         lvl_q    <= frame_i;
         cnt_q    <= pos_o;
         if (start_o)
            armed_q <= 1'b1;
      end
   end

   assign lvl_prev_o = lvl_q;
   assign armed_o    = armed_q;
endmodule

// File: rtl/pcm_rx_shifter.sv
`timescale 1ns/1ps
// Keeps the most recent OUT_W serial bits, newest in bit 0.
module pcm_rx_shifter #(
   parameter int OUT_W = 24
) (
   input  logic             clk_bit,
   input  logic             rst_n,
   input  logic             sdata_i,
   output logic [OUT_W-1:0] hist_o,
   output logic [OUT_W-1:0] next_o
);
   logic [OUT_W-1:0] hist_q;

   assign next_o = {hist_q[OUT_W-2:0], sdata_i};
   assign hist_o = hist_q;

   always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n)
         hist_q <= '0;
      else
         hist_q <= next_o;
   end
endmodule

// File: rtl/pcm_rx_extend.sv
`timescale 1ns/1ps
// Takes the low bits of a window and sign-extends them to the full width.
module pcm_rx_extend
   import pcm_rx_pkg::*;
#(
   parameter int OUT_W   = 24,
   parameter int W_MID   = 20,
   parameter int W_SHORT = 16
) (
   input  logic [OUT_W-1:0] window_i,
   input  wid_e             width_i,
   output logic [OUT_W-1:0] word_o
);
   localparam int N_LEN = 3;

   logic [OUT_W-1:0] cand [N_LEN];

   for (genvar g = 0; g < N_LEN; g++) begin : g_len
      localparam int LEN = (g == 0) ? OUT_W : ((g == 1) ? W_MID : W_SHORT);
      if (LEN == OUT_W) begin : g_full
         assign cand[g] = window_i;
      end else begin : g_ext
         assign cand[g] = {{(OUT_W-LEN){window_i[LEN-1]}}, window_i[LEN-1:0]};
      end
   end

   always_comb begin
      unique case (width_i)
         WID_MID:   word_o = cand[1];
         WID_SHORT: word_o = cand[2];
         default:   word_o = cand[0];
      endcase
   end
endmodule

// File: rtl/pcm_serial_rx.sv
`timescale 1ns/1ps
// Stereo serial PCM receiver: four framings, three word lengths.
module pcm_serial_rx
   import pcm_rx_pkg::*;
#(
   parameter int OUT_W   = 24,
   parameter int W_MID   = 20,
   parameter int W_SHORT = 16
) (
   input  logic             clk_bit,
   input  logic             rst_n,
   input  logic             frame_i,
   input  logic             sdata_i,
   input  logic [1:0]       cfg_mode,
   input  logic [1:0]       cfg_width,
   output logic [OUT_W-1:0] left_data,
   output logic             left_valid,
   output logic [OUT_W-1:0] right_data,
   output logic             right_valid
);
   localparam int CNT_W = $clog2(2*OUT_W + 1) + 1;
   localparam logic [CNT_W-1:0] LEN_FULL  = CNT_W'(OUT_W);
   localparam logic [CNT_W-1:0] LEN_MID   = CNT_W'(W_MID);
   localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(W_SHORT);

   if (W_SHORT < 2 || W_MID <= W_SHORT || OUT_W <= W_MID) begin : g_bad_len
      $error("pcm_serial_rx: word lengths must satisfy 2 <= W_SHORT < W_MID < OUT_W");
   end

   fmt_e fmt;
   wid_e wid;
   assign fmt = fmt_e'(cfg_mode);
   assign wid = wid_e'(cfg_width);

   logic             start;
   logic [CNT_W-1:0] pos;
   logic             lvl_prev;
   logic             armed;
   logic [OUT_W-1:0] hist;
   logic [OUT_W-1:0] hist_next;
   logic [OUT_W-1:0] window;
   logic [OUT_W-1:0] word;
   logic [CNT_W-1:0] len;
   logic             take_l;
   logic             take_r;

   pcm_rx_framer #(.CNT_W(CNT_W)) i_framer (
      .clk_bit     (clk_bit),
      .rst_n       (rst_n),
      .frame_i     (frame_i),
      .marker_only (fmt == FMT_DSP),
      .start_o     (start),
      .pos_o       (pos),
      .lvl_prev_o  (lvl_prev),
      .armed_o     (armed)
   );

   pcm_rx_shifter #(.OUT_W(OUT_W)) i_shifter (
      .clk_bit (clk_bit),
      .rst_n   (rst_n),
      .sdata_i (sdata_i),
      .hist_o  (hist),
      .next_o  (hist_next)
   );

   // Right-justified words end before the edge that sees the frame change.
   assign window = (fmt == FMT_RGHT) ? hist : hist_next;

   pcm_rx_extend #(.OUT_W(OUT_W), .W_MID(W_MID), .W_SHORT(W_SHORT)) i_extend (
      .window_i (window),
      .width_i  (wid),
      .word_o   (word)
   );

   always_comb begin
      unique case (wid)
         WID_MID:   len = LEN_MID;
         WID_SHORT: len = LEN_SHORT;
         default:   len = LEN_FULL;
      endcase
   end

   always_comb begin
      take_l = 1'b0;
      take_r = 1'b0;
      unique case (fmt)
         FMT_I2S: begin
            take_l = (pos == len) && !frame_i;
            take_r = (pos == len) &&  frame_i;
         end
         FMT_LEFT: begin
            take_l = (pos == len - 1'b1) &&  frame_i;
            take_r = (pos == len - 1'b1) && !frame_i;
         end
         FMT_RGHT: begin
            take_l = start && armed &&  lvl_prev;
            take_r = start && armed && !lvl_prev;
         end
         default: begin
            take_l = (pos == len - 1'b1);
            take_r = (pos == {len[CNT_W-2:0], 1'b0} - 1'b1);
         end
      endcase
   end

   always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n) begin
         left_data   <= '0;
         right_data  <= '0;
         left_valid  <= 1'b0;
         right_valid <= 1'b0;
      end else begin
         left_valid  <= take_l;
         right_valid <= take_r;
         if (take_l)
            left_data <= word;
         if (take_r)
            right_data <= word;
      end
   end
endmodule

// File: rtl/pcm_serial_rx_chk.sv
`timescale 1ns/1ps
module pcm_serial_rx_chk #(
   parameter int OUT_W   = 24,
   parameter int W_SHORT = 16
) (
   input logic             clk_bit,
   input logic             rst_n,
   input logic [1:0]       cfg_width,
   input logic [OUT_W-1:0] left_data,
   input logic             left_valid,
   input logic [OUT_W-1:0] right_data,
   input logic             right_valid
);
   logic [OUT_W-W_SHORT:0] l_top;
   logic [OUT_W-W_SHORT:0] r_top;
   assign l_top = left_data[OUT_W-1:W_SHORT-1];
   assign r_top = right_data[OUT_W-1:W_SHORT-1];

   a_r8_one_channel: assert property (@(posedge clk_bit) disable iff (!rst_n)
      $onehot0({left_valid, right_valid}));

   a_r8_left_pulse: assert property (@(posedge clk_bit) disable iff (!rst_n)
      left_valid |=> !left_valid);

   a_r8_right_pulse: assert property (@(posedge clk_bit) disable iff (!rst_n)
      right_valid |=> !right_valid);

   a_r8_left_hold: assert property (@(posedge clk_bit) disable iff (!rst_n)
      !left_valid |-> $stable(left_data));

   a_r8_right_hold: assert property (@(posedge clk_bit) disable iff (!rst_n)
      !right_valid |-> $stable(right_data));

   a_r7_left_sign: assert property (@(posedge clk_bit) disable iff (!rst_n)
      (left_valid && cfg_width == 2'd2 && $stable(cfg_width)) |-> ((&l_top) || !(|l_top)));

   a_r7_right_sign: assert property (@(posedge clk_bit) disable iff (!rst_n)
      (right_valid && cfg_width == 2'd2 && $stable(cfg_width)) |-> ((&r_top) || !(|r_top)));
endmodule

bind pcm_serial_rx pcm_serial_rx_chk #(.OUT_W(OUT_W), .W_SHORT(W_SHORT)) i_chk (
   .clk_bit     (clk_bit),
   .rst_n       (rst_n),
   .cfg_width   (cfg_width),
   .left_data   (left_data),
   .left_valid  (left_valid),
   .right_data  (right_data),
   .right_valid (right_valid)
);

// File: tb/test_pcm_serial_rx.sv
`timescale 1ns/1ps
module test_pcm_serial_rx;
   logic        clk_bit = 1'b0;
   logic        clk_en  = 1'b1;
   logic        rst_n   = 1'b0;
   logic        frame_i = 1'b0;
   logic        sdata_i = 1'b0;
   logic [1:0]  cfg_mode  = 2'd0;
   logic [1:0]  cfg_width = 2'd0;
   logic [23:0] left_data, right_data;
   logic        left_valid, right_valid;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;
   bit mon_on = 1'b0;
   string req_tag = "R1";
   logic [23:0] exp_l [8];
   logic [23:0] exp_r [8];
   int nl = 0;
   int nr = 0;
   logic [31:0] seed = 32'h1234_5678;

   pcm_serial_rx i_pcm_serial_rx (
      .clk_bit(clk_bit), .rst_n(rst_n), .frame_i(frame_i), .sdata_i(sdata_i),
      .cfg_mode(cfg_mode), .cfg_width(cfg_width),
      .left_data(left_data), .left_valid(left_valid),
      .right_data(right_data), .right_valid(right_valid));

   // 250 MHz bit clock, gateable
   always begin
      #2;
      if (clk_en) clk_bit = ~clk_bit;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] sext(input logic [23:0] v, input int w);
      if (w == 16) return {{8{v[15]}}, v[15:0]};
      if (w == 20) return {{4{v[19]}}, v[19:0]};
      return v;
   endfunction

   // Monitor: compares every strobe against the queue of expected words
   always @(negedge clk_bit) begin
      if (rst_n && mon_on) begin
         if (left_valid) begin
            check(nl < 8 && left_data === exp_l[nl & 7], req_tag, {8'h0, left_data}, {8'h0, exp_l[nl & 7]});
            nl++;
         end
         if (right_valid) begin
            check(nr < 8 && right_data === exp_r[nr & 7], req_tag, {8'h0, right_data}, {8'h0, exp_r[nr & 7]});
            nr++;
         end
      end
   end

   task automatic drive_bit(input logic f, input logic d, input bit pause);
      @(negedge clk_bit);
      frame_i = f;
      sdata_i = d;
      if (pause) begin
         #1;
         clk_en = 1'b0;
         #37;
         clk_en = 1'b1;
      end
   endtask

   function automatic logic half_bit(input int mode, input int w, input int h,
                                     input logic [23:0] v, input int i);
      case (mode)
         0: return (i >= 1 && i <= w) ? v[w-i] : 1'b1;       // I2S
         1: return (i < w) ? v[w-1-i] : 1'b1;                // left-justified
         default: return (i >= h - w) ? v[h-1-i] : 1'b1;     // right-justified
      endcase
   endfunction

   task automatic run_case(input int mode, input int wcode, input int variant);
      int w;
      int h;
      bit gap;
      logic idle;
      logic lft;
      logic [23:0] vl [4];
      logic [23:0] vr [4];
      logic [23:0] mask;
      w = (wcode == 1) ? 20 : ((wcode == 2) ? 16 : 24);
      gap = (variant == 2);
      if (variant == 0) h = 32;
      else h = (mode == 0) ? w + 1 : w;
      idle = (mode == 0) ? 1'b1 : 1'b0;
      lft  = (mode == 0) ? 1'b0 : 1'b1;
      mask = 24'hFF_FFFF >> (24 - w);
      case (mode)
         0: req_tag = "R3";
         1: req_tag = "R4";
         2: req_tag = "R5";
         default: req_tag = "R6";
      endcase
      for (int f = 0; f < 4; f++) begin
         if (f == 0) begin
            vl[f] = 24'd1 << (w - 1);
            vr[f] = (24'd1 << (w - 1)) - 24'd1;
         end else begin
            seed = seed * 32'd1103515245 + 32'd12345;
            vl[f] = seed[31:8] & mask;
            seed = seed * 32'd1103515245 + 32'd12345;
            vr[f] = seed[31:8] & mask;
         end
         exp_l[f] = sext(vl[f], w);
         exp_r[f] = sext(vr[f], w);
      end
      // reset with the new configuration (R2 encodings)
      mon_on = 1'b0;
      @(negedge clk_bit);
      rst_n = 1'b0;
      cfg_mode = 2'(mode);
      cfg_width = 2'(wcode);
      frame_i = idle;
      sdata_i = 1'b1;
      repeat (2) @(negedge clk_bit);
      check(left_data == 24'h0 && right_data == 24'h0 && !left_valid && !right_valid,
            "R1", {left_valid, right_valid, 6'h0, left_data}, 32'h0);
      rst_n = 1'b1;
      nl = 0;
      nr = 0;
      mon_on = 1'b1;
      // no frame change yet: nothing may be emitted
      for (int i = 0; i < 30; i++) drive_bit(idle, 1'b1, 1'b0);
      @(negedge clk_bit);
      check(nl == 0 && nr == 0, "R1", 32'(nl + nr), 32'h0);
      for (int f = 0; f < 4; f++) begin
         if (mode == 3) begin
            for (int i = 0; i < 2*h; i++)
               drive_bit(i == 0, (i < w) ? vl[f][w-1-i] : ((i < 2*w) ? vr[f][2*w-1-i] : 1'b1),
                         gap && (i == 5 || i == w + 3));
         end else begin
            for (int i = 0; i < h; i++)
               drive_bit(lft, half_bit(mode, w, h, vl[f], i), gap && i == 5);
            for (int i = 0; i < h; i++)
               drive_bit(~lft, half_bit(mode, w, h, vr[f], i), gap && i == 7);
         end
      end
      // short tail: closes the last right-justified word, too short for a new one
      for (int i = 0; i < 3; i++) drive_bit((mode == 3) ? 1'b0 : lft, 1'b1, 1'b0);
      repeat (2) @(negedge clk_bit);
      check(nl == 4, "R9", 32'(nl), 32'd4);
      check(nr == 4, "R9", 32'(nr), 32'd4);
      mon_on = 1'b0;
   endtask

   initial begin
      // R2: all-zero configuration behaves as I2S, 24-bit (covered by mode 0, wcode 0)
      // R7: widths 16/20 carry most-negative and positive extremes
      repeat (3) @(negedge clk_bit);
      for (int m = 0; m < 4; m++)
         for (int wc = 0; wc < 4; wc++)
            for (int v = 0; v < 3; v++)
               run_case(m, wc, v);
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #800000;
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule